// File: doc/BRIEF.md
# DMA Address and Byte-Lane Generator

This block holds the transfer address for a single DMA channel and moves it along as cycles finish. The channel runs in one of two classes. A byte-wide channel steps address bits 15..0 by one per cycle. A word-wide channel steps bits 16..1 by one per cycle, so the byte address always moves by two and stays even. In both classes the carry or borrow never leaves its counting window. The page bits above the window keep the value they were given at load, and only a new load changes them.

The block also drives the byte-lane controls for each cycle. A word-wide channel always asserts both the active-low high-byte enable and A0 low, and it ignores the memory-width input. A byte-wide channel drives A0 from the address and enables the high lane on odd addresses. It raises the swap enable when memory reports 16-bit width at an odd address, which steers the low I/O byte onto the high memory data lane. Software-style setup goes through a synchronous load port, and the DMA engine pulses a strobe at the end of each completed cycle.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is low, and on the first clock after reset is released, the address reads 0.
- R2: A clock with `load_en` high writes all 24 bits of `load_addr` into the address. Load wins over a `step` in the same clock. After a load, a word-wide channel shows the value with bit 0 forced to 0.
- R3: On a byte-wide channel (`wide`=0), a `step` adds or subtracts one on bits 15..0. The count wraps from 16'hFFFF to 0 (or from 0 to 16'hFFFF), and bits 23..16 stay unchanged.
- R4: On a word-wide channel (`wide`=1), a `step` adds or subtracts one on bits 16..1. The count wraps within those 16 bits, bits 23..17 stay unchanged, and address bit 0 always reads 0.
- R5: `dir_down`=0 makes a step count up and `dir_down`=1 makes it count down.
- R6: With `load_en` and `step` both low, the address holds its value.
- R7: On a byte-wide channel, `a0` equals address bit 0, and `bhe_n` is its inverse, so it is low at odd addresses.
- R8: On a word-wide channel, `bhe_n`=0, `a0`=0 and `swap_en`=0 whatever the value of `mem16`.
- R9: `swap_en` is 1 exactly when the channel is byte-wide, `mem16`=1 and address bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write `load_addr` into the address |
| load_addr | input | 24 | Start address |
| dir_down | input | 1 | 1 = count down, 0 = count up |
| wide | input | 1 | 1 = word-wide channel class, 0 = byte-wide |
| step | input | 1 | One DMA cycle completed |
| mem16 | input | 1 | Memory reports 16-bit width |
| addr | output | 24 | Transfer address |
| bhe_n | output | 1 | Active-low high-byte enable |
| a0 | output | 1 | Address bit 0 driven to the bus |
| swap_en | output | 1 | Route the low I/O byte to the high memory lane |

## Verification
The bench aims at the window edges in both directions and both classes. A carry that leaks into the page bits turns 12FFFF into 130000 instead of 120000, and a word-wide borrow that misses bit 16 gives A4FFFE instead of A5FFFE. An odd start on a word-wide channel catches a design that steps from bit 0 or shows a non-zero A0. A load and a step in the same clock exposes a design that increments a freshly loaded value. The swap and lane checks cover `mem16` on both classes and at both address parities, so a swap that fires on even addresses or on word-wide channels is reported.

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              dir_down,
  input  logic              wide,
  input  logic              step,
  input  logic              mem16,
  output logic [ADDR_W-1:0] addr,
  output logic              bhe_n,
  output logic              a0,
  output logic              swap_en
);

  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [WIN_W-1:0]  delta;
  logic [WIN_W-1:0]  win_n, win_w;
  logic [ADDR_W-1:0] next_n, next_w;

  assign delta  = dir_down ? ~(ONE - ONE) : ONE;
  assign win_n  = addr_q[WIN_W-1:0] + delta;
  assign win_w  = addr_q[WIN_W:1] + delta;
  assign next_n = {addr_q[ADDR_W-1:WIN_W], win_n};
  assign next_w = {addr_q[ADDR_W-1:WIN_W+1], win_w, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_en) addr_q <= load_addr;
    else if (step)    addr_q <= wide ? next_w : next_n;
  end

  assign addr    = wide ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
  assign a0      = addr[0];
  assign bhe_n   = wide ? 1'b0 : ~addr_q[0];
  assign swap_en = ~wide & mem16 & addr_q[0];

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !step |=> $stable(addr_q));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> addr_q == $past(load_addr));

  // R3
  narrow_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && step && !wide |=> addr_q[ADDR_W-1:WIN_W] == $past(addr_q[ADDR_W-1:WIN_W]));

  // R4
  wide_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && step && wide |=> addr_q[ADDR_W-1:WIN_W+1] == $past(addr_q[ADDR_W-1:WIN_W+1]));

  // R8
  wide_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> !bhe_n && !a0 && !swap_en && !addr[0]);

  // R9
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |-> mem16 && !wide && a0 && !bhe_n);

endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_en = 0, dir_down = 0, wide = 0, step = 0, mem16 = 0;
  logic [23:0] load_addr = '0;
  logic [23:0] addr;
  logic        bhe_n, a0, swap_en;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dma_addr_gen u0 (.clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .dir_down(dir_down), .wide(wide), .step(step), .mem16(mem16),
    .addr(addr), .bhe_n(bhe_n), .a0(a0), .swap_en(swap_en));

  // {wide, dir_down, start, expected after one step}
  localparam logic [49:0] VEC [8] = '{
    {1'b0, 1'b0, 24'h12FFFF, 24'h120000},
    {1'b0, 1'b1, 24'h340000, 24'h34FFFF},
    {1'b0, 1'b0, 24'h000123, 24'h000124},
    {1'b0, 1'b1, 24'h000001, 24'h000000},
    {1'b1, 1'b0, 24'h5FFFFE, 24'h5E0000},
    {1'b1, 1'b1, 24'hA40000, 24'hA5FFFE},
    {1'b1, 1'b0, 24'h000100, 24'h000102},
    {1'b1, 1'b0, 24'h000101, 24'h000102}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lanes(input string req, input logic eb, input logic ea, input logic es);
    chk(req, {21'd0, bhe_n, a0, swap_en}, {21'd0, eb, ea, es});
  endtask

  task automatic do_load(input logic [23:0] v);
    load_en = 1; load_addr = v;
    @(negedge clk); load_en = 0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", addr, 24'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", addr, 24'h0);

    for (int i = 0; i < 8; i++) begin
      wide = VEC[i][49]; dir_down = VEC[i][48];
      do_load(VEC[i][47:24]);
      chk("R2 load", addr, wide ? {VEC[i][47:25], 1'b0} : VEC[i][47:24]);
      step = 1; @(negedge clk); step = 0;
      chk("R3/R4/R5 step", addr, VEC[i][23:0]);
    end

    // R6 hold
    wide = 0; dir_down = 0;
    do_load(24'h00ABCD);
    @(negedge clk); @(negedge clk);
    chk("R6 hold", addr, 24'h00ABCD);

    // R2 load wins over step
    load_en = 1; step = 1; load_addr = 24'h777770;
    @(negedge clk); load_en = 0; step = 0;
    chk("R2 priority", addr, 24'h777770);

    // R3 several steps up
    step = 1; @(negedge clk); @(negedge clk); @(negedge clk); step = 0;
    chk("R3 three steps", addr, 24'h777773);

    // R7/R9 byte-wide lanes
    mem16 = 1; do_load(24'h000011);
    lanes("R7/R9 odd mem16", 1'b0, 1'b1, 1'b1);
    mem16 = 0; #1;
    lanes("R9 odd mem8", 1'b0, 1'b1, 1'b0);
    mem16 = 1; do_load(24'h000010);
    lanes("R7/R9 even mem16", 1'b1, 1'b0, 1'b0);

    // R8 word-wide lanes ignore mem16
    wide = 1; mem16 = 1; do_load(24'h000011);
    lanes("R8 wide mem16", 1'b0, 1'b0, 1'b0);
    chk("R4 wide bit0", addr, 24'h000010);
    mem16 = 0; #1;
    lanes("R8 wide mem8", 1'b0, 1'b0, 1'b0);

    // R4/R5 word-wide down across window edge
    dir_down = 1; do_load(24'h010000);
    step = 1; @(negedge clk); step = 0;
    chk("R4/R5 wide down", addr, 24'h00FFFE);

    // R1 reset clears a loaded value
    rst_n = 0; @(negedge clk);
    chk("R1 reclear", addr, 24'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule